// File: doc/BRIEF.md
# Bus Initiator Transaction Sequencer

This block is the master side of a 32-bit multiplexed address/data bus in the PCI style. A client places one transaction on a simple request port: a 4-bit command, a 64-bit address and a word count. The client also supplies write words as they are consumed and takes read words as they arrive. Once grant is present the sequencer runs the bus cycle. It drives the cycle-framing strobe, the initiator-ready strobe, the command/byte-enable lanes and the address/data lanes. It samples target-ready, device-select, stop and grant. When the bus is released it reports a one-clock completion pulse carrying a status code and the number of words moved.

The controller has five states. `S_IDLE` waits for a request while grant is low (transition IDLE→ADDR). `S_ADDR` is the first address phase. It goes to `S_DAC2` when the upper address half is nonzero, otherwise straight to `S_DATA`. `S_DAC2` carries the upper address half (DAC2→DATA). `S_DATA` holds initiator-ready asserted and counts data phases. It leaves in one of two ways. DATA→IDLE happens when the final word transfers. DATA→RELEASE happens on a device-select timeout, or on a stop that does not coincide with a final transfer. `S_RELEASE` keeps initiator-ready low for one clock with the framing strobe high (RELEASE→IDLE).

Top module: `pci_initiator_seq`

## Requirements
- R1: With address bits 63:32 all zero there is exactly one address phase. In it `frame_n`=0, `irdy_n`=1, `ad_o` carries address bits 31:0 and `cbe_n` carries the command.
- R2: With any of address bits 63:32 set there are two address phases. The first has `cbe_n`=4'b1101 and `ad_o`=address[31:0]. The second has `ad_o`=address[63:32] and `cbe_n`=command. In both phases `ad_hi`=address[63:32] and `cbe_hi_n`=command.
- R3: A word moves only on a clock where `irdy_n`, `trdy_n` and `devsel_n` are all 0. `done_count` equals the number of such clocks.
- R4: During a target wait (initiator ready, target not ready) the write data on `ad_o` stays unchanged.
- R5: `frame_n` is high during the final data phase. `irdy_n` is released only after that, so the clock before `done` always shows `frame_n`=1 and `irdy_n`=0.
- R6: If stop is sampled with target-ready on a word, that word completes and the bus is released. The status is 2 (disconnect) and `done_count` gives the words moved.
- R7: If `devsel_n` is not seen low within 5 data clocks, the sequencer does a master abort. `frame_n` stays high with `irdy_n` low for one clock, and then both go high. The status is 1 and the count is 0.
- R8: If the latency count (LAT_CYCLES clocks since the transaction start) has expired and `gnt_n` is high, the next data phase is made final. The status is 3 when fewer words than requested moved.
- R9: A command of 4'b0001 (special cycle) expects no device select. It keeps data on the bus with `irdy_n` low for at least 4 clocks, then ends by master abort with status 0 and count 0.
- R10: A request is accepted only in idle with `gnt_n`=0. `req_ready` is never high while `gnt_n`=1, and `done` is a single-clock pulse.
- R11: `irdy_n` goes low on the clock right after the last address phase, well within 8 clocks.
- R12: After reset `frame_n`=1, `irdy_n`=1, `ad_oe`=0 and `done`=0.
- R13: Command bit 0 set means a write. Each transferred word of a write pulses `wr_take` with the current `wr_data` on `ad_o`. Each transferred word of a read pulses `rd_valid`, with `rd_data` equal to `ad_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | 64 | Byte address |
| req_len | input | LEN_W | Words to move (0 treated as 1) |
| wr_data | input | 32 | Current write word |
| wr_take | output | 1 | Write word consumed |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| done | output | 1 | Completion pulse |
| done_status | output | 2 | 0 ok, 1 master abort, 2 disconnect, 3 preempted |
| done_count | output | LEN_W | Words moved |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Cycle framing strobe, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| cbe_n | output | 4 | Command / byte enables |
| ad_o | output | 32 | Address/data out |
| ad_oe | output | 1 | Address/data drive enable |
| ad_i | input | 32 | Address/data in |
| cbe_hi_n | output | 4 | Upper lanes command during address phases |
| ad_hi | output | 32 | Upper lanes address during address phases |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| stop_n | input | 1 | Target stop, active low |

## Verification
Random reads and writes mix single and burst lengths, 32- and 64-bit addresses, decode delays of zero to two clocks and wait patterns. These runs separate correct word counting and data ordering from off-by-one errors in the last-phase marking. Directed cases isolate each way a cycle can end. The cases are a target that never answers, a special cycle, a disconnect part-way through a burst, and grant removal after the latency count expires. Together they tell apart the four status codes and the release sequence each one needs.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_DAC2,
        S_DATA,
        S_RELEASE
    } seq_state_t;

    localparam logic [3:0] CMD_DAC     = 4'b1101;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;

    localparam logic [1:0] ST_OK      = 2'd0;
    localparam logic [1:0] ST_MABORT  = 2'd1;
    localparam logic [1:0] ST_DISC    = 2'd2;
    localparam logic [1:0] ST_PREEMPT = 2'd3;
endpackage

// File: rtl/pci_lat_timer.sv
module pci_lat_timer #(
    parameter int LAT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    output logic expired
);
    localparam int LW = $clog2(LAT_CYCLES + 1);
    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (active && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LW'(LAT_CYCLES));
endmodule

// File: rtl/pci_devsel_watch.sv
module pci_devsel_watch #(
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_data,
    input  logic ignore,
    input  logic devsel_n,
    output logic timeout
);
    localparam int WW = $clog2(DEVSEL_LIMIT + 1);
    logic [WW-1:0] cnt_q;
    logic          seen_q;
    logic          claimed;

    assign claimed = !devsel_n && !ignore;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (in_data) begin
            if (claimed) begin
                seen_q <= 1'b1;
            end else if (!seen_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign timeout = in_data && !seen_q && !claimed &&
                     (cnt_q == WW'(DEVSEL_LIMIT - 1));
endmodule

// File: rtl/pci_beat_counter.sv
module pci_beat_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             xfer,
    output logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] moved
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            moved  <= '0;
        end else if (start) begin
            remain <= len;
            moved  <= '0;
        end else if (xfer) begin
            remain <= remain - 1'b1;
            moved  <= moved + 1'b1;
        end
    end
endmodule

// File: rtl/pci_initiator_seq.sv
module pci_initiator_seq
    import pci_init_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int DW           = 32,
    parameter int LAT_CYCLES   = 16,
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_cmd,
    input  logic [2*DW-1:0]  req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_take,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic [1:0]       done_status,
    output logic [LEN_W-1:0] done_count,
    input  logic             gnt_n,
    output logic             frame_n,
    output logic             irdy_n,
    output logic [3:0]       cbe_n,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_i,
    output logic [3:0]       cbe_hi_n,
    output logic [DW-1:0]    ad_hi,
    input  logic             trdy_n,
    input  logic             devsel_n,
    input  logic             stop_n
);
    localparam int AW = 2 * DW;

    seq_state_t       state_q, state_d;
    logic [3:0]       cmd_q;
    logic [AW-1:0]    addr_q;
    logic             wr_q, spec_q, dac_q, force_q;
    logic [1:0]       status_q, status_d;
    logic             done_q;

    logic             start, xfer, last_phase, empty_after;
    logic             lat_expired, dev_timeout;
    logic [LEN_W-1:0] remain, moved, len_eff;
    logic             req_spec;

    assign req_spec    = (req_cmd == CMD_SPECIAL);
    assign start       = (state_q == S_IDLE) && req_valid && !gnt_n;
    assign len_eff     = (req_spec || req_len == '0) ? LEN_W'(1) : req_len;
    assign xfer        = (state_q == S_DATA) && !trdy_n && !devsel_n && !spec_q;
    assign last_phase  = (remain == LEN_W'(1)) || force_q;
    assign empty_after = (remain == {{(LEN_W-1){1'b0}}, xfer});

    pci_lat_timer #(.LAT_CYCLES(LAT_CYCLES)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .active  (state_q != S_IDLE),
        .expired (lat_expired)
    );

    pci_devsel_watch #(.DEVSEL_LIMIT(DEVSEL_LIMIT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_data  (state_q == S_DATA),
        .ignore   (spec_q),
        .devsel_n (devsel_n),
        .timeout  (dev_timeout)
    );

    pci_beat_counter #(.LEN_W(LEN_W)) u_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .len    (len_eff),
        .xfer   (xfer),
        .remain (remain),
        .moved  (moved)
    );

    // next-state and completion status
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_ADDR;
            S_ADDR:    state_d = dac_q ? S_DAC2 : S_DATA;
            S_DAC2:    state_d = S_DATA;
            S_DATA: begin
                if (dev_timeout) begin
                    state_d  = S_RELEASE;
                    status_d = spec_q ? ST_OK : ST_MABORT;
                end else if (!stop_n) begin
                    state_d  = (xfer && last_phase) ? S_IDLE : S_RELEASE;
                    status_d = empty_after ? ST_OK : ST_DISC;
                end else if (xfer && last_phase) begin
                    state_d  = S_IDLE;
                    status_d = empty_after ? ST_OK : ST_PREEMPT;
                end
            end
            S_RELEASE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and transaction flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            addr_q   <= '0;
            wr_q     <= 1'b0;
            spec_q   <= 1'b0;
            dac_q    <= 1'b0;
            force_q  <= 1'b0;
            status_q <= ST_OK;
            done_q   <= 1'b0;
        end else begin
            status_q <= status_d;
            done_q   <= (state_d == S_IDLE) &&
                        (state_q == S_DATA || state_q == S_RELEASE);
            if (start) begin
                cmd_q   <= req_cmd;
                addr_q  <= req_addr;
                wr_q    <= req_cmd[0];
                spec_q  <= req_spec;
                dac_q   <= |req_addr[AW-1:DW];
                force_q <= 1'b0;
            end else if (state_q == S_DATA && lat_expired && gnt_n) begin
                force_q <= 1'b1;
            end
        end
    end

    // bus outputs
    always_comb begin
        frame_n  = 1'b1;
        irdy_n   = 1'b1;
        cbe_n    = 4'hF;
        ad_o     = '0;
        ad_oe    = 1'b0;
        cbe_hi_n = 4'hF;
        ad_hi    = '0;
        unique case (state_q)
            S_ADDR: begin
                frame_n = 1'b0;
                ad_oe   = 1'b1;
                ad_o    = addr_q[DW-1:0];
                cbe_n   = dac_q ? CMD_DAC : cmd_q;
                if (dac_q) begin
                    ad_hi    = addr_q[AW-1:DW];
                    cbe_hi_n = cmd_q;
                end
            end
            S_DAC2: begin
                frame_n  = 1'b0;
                ad_oe    = 1'b1;
                ad_o     = addr_q[AW-1:DW];
                cbe_n    = cmd_q;
                ad_hi    = addr_q[AW-1:DW];
                cbe_hi_n = cmd_q;
            end
            S_DATA: begin
                frame_n = last_phase;
                irdy_n  = 1'b0;
                cbe_n   = 4'h0;
                ad_oe   = wr_q;
                ad_o    = wr_q ? wr_data : '0;
            end
            S_RELEASE: begin
                irdy_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign req_ready   = (state_q == S_IDLE) && !gnt_n;
    assign wr_take     = xfer && wr_q;
    assign rd_valid    = xfer && !wr_q;
    assign rd_data     = ad_i;
    assign done        = done_q;
    assign done_status = status_q;
    assign done_count  = moved;
endmodule

// File: rtl/pci_initiator_seq_chk.sv
module pci_initiator_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_n,
    input logic          irdy_n,
    input logic [3:0]    cbe_n,
    input logic [DW-1:0] ad_o,
    input logic          ad_oe,
    input logic          trdy_n,
    input logic          devsel_n,
    input logic          stop_n,
    input logic          gnt_n,
    input logic          req_ready,
    input logic          wr_take,
    input logic          rd_valid,
    input logic          done
);
    logic [1:0] addr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_run <= '0;
        end else if (!frame_n && irdy_n) begin
            addr_run <= (addr_run == 2'd3) ? addr_run : addr_run + 1'b1;
        end else begin
            addr_run <= '0;
        end
    end

    assert_dac_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && irdy_n && cbe_n == 4'b1101) |=> (!frame_n && irdy_n && cbe_n != 4'b1101));

    assert_xfer_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take || rd_valid) |-> (!irdy_n && !trdy_n && !devsel_n));

    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && ad_oe && $past(!irdy_n && ad_oe && trdy_n && stop_n)) |-> $stable(ad_o));

    assert_frame_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> !irdy_n);

    assert_irdy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_n) |-> $past(frame_n));

    assert_ready_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !gnt_n);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_irdy_prompt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && irdy_n) |-> (addr_run < 2'd2));
endmodule

bind pci_initiator_seq pci_initiator_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .cbe_n     (cbe_n),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .trdy_n    (trdy_n),
    .devsel_n  (devsel_n),
    .stop_n    (stop_n),
    .gnt_n     (gnt_n),
    .req_ready (req_ready),
    .wr_take   (wr_take),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/tb_pci_initiator_seq.sv
module tb_pci_initiator_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 8;
    localparam int LAT   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [3:0]       req_cmd = 4'h0;
    logic [63:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [31:0]      wr_data;
    logic             wr_take, rd_valid, done;
    logic [31:0]      rd_data;
    logic [1:0]       done_status;
    logic [LEN_W-1:0] done_count;
    logic             gnt_n = 1'b0;
    logic             frame_n, irdy_n, ad_oe;
    logic [3:0]       cbe_n, cbe_hi_n;
    logic [31:0]      ad_o, ad_hi;
    logic [31:0]      ad_i = '0;
    logic             trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // target configuration, set per transaction
    int cfg_dec = 0, cfg_wait = 0, cfg_disc = 0;
    bit cfg_noresp = 0, cfg_write = 0;
    // target bookkeeping
    int t_cyc = 0, t_words = 0, t_irdy = 0;
    bit t_stop = 0, t_was_wait = 0;
    logic [31:0] t_prev_ad = '0;
    logic cur_frame = 1'b1, cur_irdy = 1'b1, hist_frame = 1'b1, hist_irdy = 1'b1;
    logic [7:0] wr_idx = '0;
    logic idx_clr = 1'b0;

    pci_initiator_seq #(.LEN_W(LEN_W), .LAT_CYCLES(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_status(done_status), .done_count(done_count),
        .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cbe_hi_n(cbe_hi_n), .ad_hi(ad_hi),
        .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] wr_pat(input int i);
        return 32'h5A00_0000 + 32'(i * 3 + 1);
    endfunction

    function automatic logic [31:0] rd_pat(input int i);
        return 32'hC300_0000 ^ 32'(i * 7 + 5);
    endfunction

    assign wr_data = wr_pat(int'(wr_idx));

    always @(posedge clk) begin
        if (idx_clr) wr_idx <= '0;
        else if (wr_take) wr_idx <= wr_idx + 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural target, drives its responses between edges
    always @(negedge clk) begin
        hist_frame = cur_frame;
        hist_irdy  = cur_irdy;
        cur_frame  = frame_n;
        cur_irdy   = irdy_n;
        if (!rst_n || irdy_n) begin
            devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            if (rst_n && !frame_n) begin
                t_cyc = 0; t_words = 0; t_stop = 0; t_was_wait = 0; t_irdy = 0;
            end
        end else begin
            t_cyc++;
            t_irdy++;
            if (t_stop || cfg_noresp) begin
                devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            end else begin
                automatic bit dv = (t_cyc > cfg_dec);
                automatic bit tr = dv && (((t_cyc - cfg_dec - 1) % (cfg_wait + 1)) == cfg_wait);
                automatic bit st = tr && (cfg_disc != 0) && (t_words == cfg_disc - 1);
                automatic int w0 = t_words;
                devsel_n = !dv; trdy_n = !tr; stop_n = !st;
                ad_i = rd_pat(w0);
                if (cfg_write && t_was_wait)
                    chk(ad_o == t_prev_ad, "R4 write data held in wait", ad_o, t_prev_ad);
                #1;
                if (cfg_write) begin
                    chk(wr_take == tr, "R3 wr_take only on transfer", wr_take, tr);
                    if (tr) chk(ad_o == wr_pat(w0), "R13 write word", ad_o, wr_pat(w0));
                end else begin
                    chk(rd_valid == tr, "R3 rd_valid only on transfer", rd_valid, tr);
                    if (tr) chk(rd_data == rd_pat(w0), "R13 read word", rd_data, rd_pat(w0));
                end
                t_prev_ad  = ad_o;
                t_was_wait = !tr;
                if (tr) begin
                    t_words++;
                    if (st) t_stop = 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_txn(input logic [3:0] cmd, input logic [63:0] addr, input int len,
                           input int dec, input int wt, input int disc, input bit noresp,
                           input bit preempt);
        automatic bit dac  = (addr[63:32] != 0);
        automatic bit spec = (cmd == 4'b0001);
        automatic int n = 0;
        automatic logic [1:0] exp_st;
        automatic int exp_cnt;
        cfg_dec = dec; cfg_wait = wt; cfg_disc = disc;
        cfg_noresp = noresp || spec; cfg_write = cmd[0] && !spec;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len); idx_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; idx_clr = 1'b0;
        if (preempt) gnt_n = 1'b1;
        #3;
        chk(!frame_n && irdy_n, "R1 first address phase strobes", {frame_n, irdy_n}, 2'b01);
        chk(ad_o == addr[31:0], "R1 low address on ad_o", ad_o, addr[31:0]);
        if (dac) begin
            chk(cbe_n == 4'b1101, "R2 dual-cycle code", cbe_n, 4'b1101);
            chk(ad_hi == addr[63:32] && cbe_hi_n == cmd, "R2 upper lanes phase 1", {cbe_hi_n, ad_hi}, {cmd, addr[63:32]});
            @(negedge clk); #3;
            chk(!frame_n && irdy_n && ad_o == addr[63:32], "R2 second address phase", ad_o, addr[63:32]);
            chk(cbe_n == cmd && cbe_hi_n == cmd, "R2 command in phase 2", {cbe_n, cbe_hi_n}, {cmd, cmd});
        end else begin
            chk(cbe_n == cmd, "R1 command on cbe_n", cbe_n, cmd);
        end
        @(negedge clk); #3;
        chk(!irdy_n, "R11 irdy asserted after address", irdy_n, 1'b0);
        while (!done && n < 300) begin
            @(negedge clk); #3;
            n++;
        end
        chk(done == 1'b1, "R10 completion reached", done, 1'b1);
        chk(hist_frame && !hist_irdy, "R5 last clock frame high irdy low", {hist_frame, hist_irdy}, 2'b10);
        if (noresp || spec) begin
            exp_st = spec ? 2'd0 : 2'd1; exp_cnt = 0;
            if (spec) chk(t_irdy >= 4, "R9 special data held", t_irdy, 4);
            else chk(done_status == exp_st, "R7 master abort status", done_status, exp_st);
        end else if (preempt) begin
            exp_st = 2'd3; exp_cnt = t_words;
            chk(done_count < LEN_W'(len) && done_count != 0, "R8 preempted burst shortened", done_count, len);
        end else if (disc != 0) begin
            exp_st = 2'd2; exp_cnt = disc;
        end else begin
            exp_st = 2'd0; exp_cnt = len;
        end
        chk(done_status == exp_st, spec ? "R9 status" : (preempt ? "R8 status" : (disc != 0 ? "R6 status" : "R10 status")), done_status, exp_st);
        chk(done_count == LEN_W'(exp_cnt), "R6 R7 R3 word count", done_count, exp_cnt);
        chk(done_count == LEN_W'(t_words), "R3 count matches target", done_count, t_words);
        @(negedge clk); #3;
        chk(!done, "R10 done single pulse", done, 1'b0);
        if (preempt) gnt_n = 1'b0;
    endtask

    initial begin
        automatic int seed = $urandom(32'h1A2B);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        chk(frame_n && irdy_n && !ad_oe && !done, "R12 reset state", {frame_n, irdy_n, ad_oe, done}, 4'b1100);
        chk(req_ready, "R10 ready when idle with grant", req_ready, 1'b1);

        gnt_n = 1'b1; req_valid = 1'b1; req_cmd = 4'b0110; req_len = 8'd1;
        repeat (4) begin
            @(negedge clk); #3;
            chk(frame_n && !req_ready, "R10 no start without grant", {frame_n, req_ready}, 2'b10);
        end
        req_valid = 1'b0; gnt_n = 1'b0;

        run_txn(4'b0110, 64'h0000_0000_0000_1000, 1, 0, 0, 0, 0, 0);
        run_txn(4'b0111, 64'h0000_0012_8000_0040, 8, 0, 0, 0, 0, 0);
        run_txn(4'b0111, 64'h0000_0000_0000_2000, 4, 1, 2, 0, 0, 0);
        run_txn(4'b0110, 64'h0000_0000_0000_3000, 5, 0, 1, 2, 0, 0);
        run_txn(4'b0111, 64'h0000_0000_0000_3100, 6, 2, 0, 1, 0, 0);
        run_txn(4'b0110, 64'h0000_0000_0000_4000, 3, 0, 0, 0, 1, 0);
        run_txn(4'b0001, 64'h0000_0000_0000_0000, 1, 0, 0, 0, 0, 0);
        run_txn(4'b0111, 64'h0000_0000_0000_5000, 12, 0, 0, 0, 0, 1);
        run_txn(4'b0110, 64'h0000_0003_0000_6000, 12, 1, 1, 0, 0, 1);

        for (int i = 0; i < 24; i++) begin
            automatic logic [3:0] c = ($urandom % 2) ? 4'b0111 : 4'b0110;
            automatic logic [63:0] a;
            automatic int l = 1 + ($urandom % 6);
            automatic int d = $urandom % 3;
            automatic int w = $urandom % 3;
            automatic int ds = 0;
            a[31:0]  = $urandom & 32'hFFFF_FFFC;
            a[63:32] = ($urandom % 3 == 0) ? ($urandom | 32'h1) : 32'h0;
            if (l > 1 && ($urandom % 4 == 0)) ds = 1 + ($urandom % (l - 1));
            run_txn(c, a, l, d, w, ds, 0, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule